// File: doc/BRIEF.md
# Configurable PCM Audio Serial Output

This block turns stereo PCM sample pairs into a three-wire serial audio stream made of a bit clock, a left/right clock and a data line. A bit-clock enable tick drives the timing. Each tick toggles the bit clock. On every falling bit-clock edge, the block moves one bit through a stereo frame. The frame can be 32, 48 or 64 bit clocks long, and each channel takes half of it. Samples are 16 bits wide. Each one is sent MSB first, and zeros fill the rest of its channel slot.

Configuration inputs set the following:
- the frame length;
- which level of the left/right clock marks the left channel;
- I2S framing or normal framing;
- a soft mute that ramps a per-frame gain down to zero or back up;
- zeroing of output while an error flag is raised.

All configuration is taken only at a frame boundary. At that same boundary the block accepts a new sample pair through a valid/ready handshake. If no pair is offered, the last pair is sent again and an underrun pulse is raised. A request strobe halfway through each frame tells the upstream source to get the next pair ready.

Top module: `pcm_serial_out`

## Requirements
- R1: The frame-length field `cfgMode` selects 32 bit clocks (00), 48 (01) or 64 (10). The left/right clock holds each channel level for exactly half the frame.
- R2: Field value 11 is reserved. It gives 64-bit-clock frames and holds `cfgErr` high for as long as it stays latched. `cfgErr` is low for every other value.
- R3: With `cfgLrPol` = 1 the left/right clock is high during the left slot and low during the right slot. With `cfgLrPol` = 0 the levels are the other way round.
- R4: In normal framing (`cfgI2s` = 0), a sample's MSB is on the data line during the first bit clock of its slot, and bit 15-k follows on bit clock k. Every slot bit from 16 onward is 0.
- R5: In I2S framing (`cfgI2s` = 1), the data stream is the normal stream delayed by one bit clock. The MSB therefore comes one bit clock after each left/right clock transition.
- R6: Soft mute works through a 6-bit gain that moves one step per frame toward 0 (`cfgSoftMute` = 1) or toward 63 (`cfgSoftMute` = 0). Gain 63 sends the sample unchanged. Any other gain g sends (sample × g) >>> 6, computed signed. The first frame after mute is set uses gain 62.
- R7: If `cfgMuteOnErr` and `errIn` are both high at a frame boundary, both words of that frame are 0. With `cfgMuteOnErr` low, `errIn` has no effect.
- R8: `sampleReady` is high for a single clock at each frame boundary. A pair on `leftIn`/`rightIn` is taken when `sampleValid` is high in that cycle.
- R9: If `sampleValid` is low at a frame boundary, the last accepted pair is sent again and `underrun` pulses for one clock.
- R10: A configuration change made in the middle of a frame takes effect only from the next frame boundary.
- R11: `bclkOut` toggles on each clock with `bclkTick` high and holds otherwise. `lrclkOut` and `sdataOut` change only as `bclkOut` falls.
- R12: `sampleReq` pulses for one clock as the right slot begins, once per frame.
- R13: After reset, `bclkOut`, `lrclkOut`, `sdataOut`, `sampleReady`, `sampleReq`, `underrun` and `cfgErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bclkTick | input | 1 | Enable that toggles the bit clock |
| sampleValid | input | 1 | A sample pair is offered |
| sampleReady | output | 1 | Pair accepted this cycle (frame boundary) |
| leftIn | input | 16 | Left sample, two's complement |
| rightIn | input | 16 | Right sample, two's complement |
| errIn | input | 1 | Error flag sampled at frame boundary |
| cfgMode | input | 2 | Frame length select |
| cfgLrPol | input | 1 | Left/right clock level for the left slot |
| cfgI2s | input | 1 | 1 = I2S framing, 0 = normal framing |
| cfgSoftMute | input | 1 | Ramp gain toward zero |
| cfgMuteOnErr | input | 1 | Zero output while errIn is high |
| bclkOut | output | 1 | Serial bit clock |
| lrclkOut | output | 1 | Left/right clock |
| sdataOut | output | 1 | Serial data, changes on falling bit clock |
| sampleReq | output | 1 | Pulse at right slot start |
| underrun | output | 1 | Pulse when no pair was offered at a boundary |
| cfgErr | output | 1 | Reserved frame-length value is active |

## Verification
Assertions check the following on every cycle:
- the bit clock moves only on a tick;
- the left/right clock and the data line change only on a falling bit-clock edge;
- latched configuration holds between frame boundaries;
- the gain moves at most one step, and only at a boundary;
- underrun pulses follow a boundary that had no valid pair;
- the request strobe always falls inside the right slot.

The bench scenarios check what needs a whole decoded frame:
- slot lengths for each frame-length value;
- MSB position and zero padding;
- the one-bit I2S delay;
- exact scaled words at the start and end of a soft-mute ramp;
- zeroing on error;
- repetition of stale pairs;
- a mid-frame change that waits for the next frame.

// File: rtl/pcm_out_pkg.sv
package pcm_out_pkg;
  // Width of the bit index inside a frame (longest frame is 64 bit clocks).
  localparam int POS_W = 6;

  // Strobes and next-bit information from control to datapath.
  typedef struct packed {
    logic             fall;        // bit clock falls this cycle
    logic             frameStart;  // falling edge that starts a new frame
    logic             nextLeft;    // next bit lies in the left slot
    logic [POS_W-1:0] nextPos;     // next bit position inside its slot
    logic             i2sNext;     // framing in effect for the next bit
  } ctrlStrobe_t;
endpackage

// File: rtl/pcm_gain_scaler.sv
module pcm_gain_scaler #(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 6
) (
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [GAIN_W-1:0]   gain,
  input  logic                zeroForce,
  output logic [SAMPLE_W-1:0] sampleOut
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_FULL = {GAIN_W{1'b1}};

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    prod    = PROD_W'($signed(sampleIn) * $signed({1'b0, gain}));
    shifted = prod >>> GAIN_W;
    if (zeroForce)
      sampleOut = '0;
    else if (gain == GAIN_FULL)
      sampleOut = sampleIn;
    else
      sampleOut = shifted[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/pcm_out_ctrl.sv
module pcm_out_ctrl
  import pcm_out_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bclkTick,
  input  logic        sampleValid,
  input  logic [1:0]  cfgMode,
  input  logic        cfgLrPol,
  input  logic        cfgI2s,
  output ctrlStrobe_t strb,
  output logic        bclkOut,
  output logic        lrclkOut,
  output logic        sampleReady,
  output logic        sampleReq,
  output logic        underrun,
  output logic        cfgErr
);
  localparam logic [1:0] MODE_RSVD = 2'b11;

  function automatic logic [POS_W-1:0] halfOf(input logic [1:0] m);
    case (m)
      2'b00:   return POS_W'(16);
      2'b01:   return POS_W'(24);
      default: return POS_W'(32);
    endcase
  endfunction

  function automatic logic [POS_W-1:0] lastOf(input logic [1:0] m);
    case (m)
      2'b00:   return POS_W'(31);
      2'b01:   return POS_W'(47);
      default: return POS_W'(63);
    endcase
  endfunction

  logic             bclkQ, lrQ, reqQ, undQ, errQ;
  logic [POS_W-1:0] bitIdx;
  logic [1:0]       modeQ;
  logic             polQ, i2sQ;

  logic             fall, atLast, frameStart;
  logic [1:0]       nextMode;
  logic             nextPol, nextI2s, nextLeft;
  logic [POS_W-1:0] nextIdx, nextHalf, nextPos;

  always_comb begin
    fall       = bclkTick & bclkQ;
    atLast     = (bitIdx == lastOf(modeQ));
    frameStart = fall & atLast;
    nextMode   = frameStart ? cfgMode  : modeQ;
    nextPol    = frameStart ? cfgLrPol : polQ;
    nextI2s    = frameStart ? cfgI2s   : i2sQ;
    nextIdx    = atLast ? '0 : bitIdx + 1'b1;
    nextHalf   = halfOf(nextMode);
    nextLeft   = (nextIdx < nextHalf);
    nextPos    = nextLeft ? nextIdx : nextIdx - nextHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ  <= 1'b0;
      bitIdx <= lastOf(2'b00);
      modeQ  <= 2'b00;
      polQ   <= 1'b0;
      i2sQ   <= 1'b0;
      lrQ    <= 1'b0;
      reqQ   <= 1'b0;
      undQ   <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      if (bclkTick) bclkQ <= ~bclkQ;
      if (fall) begin
        bitIdx <= nextIdx;
        lrQ    <= nextLeft ? nextPol : ~nextPol;
      end
      if (frameStart) begin
        modeQ <= cfgMode;
        polQ  <= cfgLrPol;
        i2sQ  <= cfgI2s;
        errQ  <= (cfgMode == MODE_RSVD);
      end
      reqQ <= fall & ~atLast & (nextIdx == halfOf(modeQ));
      undQ <= frameStart & ~sampleValid;
    end
  end

  assign strb.fall       = fall;
  assign strb.frameStart = frameStart;
  assign strb.nextLeft   = nextLeft;
  assign strb.nextPos    = nextPos;
  assign strb.i2sNext    = nextI2s;

  assign bclkOut     = bclkQ;
  assign lrclkOut    = lrQ;
  assign sampleReady = frameStart;
  assign sampleReq   = reqQ;
  assign underrun    = undQ;
  assign cfgErr      = errQ;

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(modeQ) && $stable(polQ) && $stable(i2sQ)));
  // R11
  bclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bclkTick |=> $stable(bclkOut));
  // R11
  bclk_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    bclkTick |=> (bclkOut != $past(bclkOut)));
  // R11
  lr_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fall |=> $stable(lrclkOut));
  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= lastOf(modeQ));
  // R8
  ready_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> bclkOut);
  // R9
  underrun_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(sampleReady && !sampleValid));
  // R12
  req_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |-> (lrclkOut != polQ));
endmodule

// File: rtl/pcm_out_dp.sv
module pcm_out_dp
  import pcm_out_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                errIn,
  input  logic                cfgSoftMute,
  input  logic                cfgMuteOnErr,
  output logic                sdataOut
);
  localparam int NCH   = 2;
  localparam int SEL_W = $clog2(SAMPLE_W);
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

  logic [NCH-1:0][SAMPLE_W-1:0] inCh, heldCh, srcCh, newCh, wordCh, curCh;
  logic [GAIN_W-1:0]            gainQ, gainNext;
  logic                         take, muteNext, prevBit, sdataQ, normBit;
  logic [SAMPLE_W-1:0]          word;
  logic [SEL_W-1:0]             bitSel;

  assign inCh[0] = leftIn;
  assign inCh[1] = rightIn;

  always_comb begin
    take     = strb.frameStart & sampleValid;
    muteNext = cfgMuteOnErr & errIn;
    if (cfgSoftMute)
      gainNext = (gainQ == '0) ? '0 : gainQ - 1'b1;
    else
      gainNext = (gainQ == GAIN_MAX) ? GAIN_MAX : gainQ + 1'b1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign srcCh[ch] = take ? inCh[ch] : heldCh[ch];
    assign curCh[ch] = strb.frameStart ? newCh[ch] : wordCh[ch];

    pcm_gain_scaler #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
      .sampleIn  (srcCh[ch]),
      .gain      (gainNext),
      .zeroForce (muteNext),
      .sampleOut (newCh[ch])
    );
  end

  always_comb begin
    word    = strb.nextLeft ? curCh[0] : curCh[1];
    bitSel  = SEL_W'(SAMPLE_W - 1) - SEL_W'(strb.nextPos);
    normBit = 1'b0;
    if (strb.nextPos < POS_W'(SAMPLE_W)) normBit = word[bitSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCh  <= '0;
      wordCh  <= '0;
      gainQ   <= GAIN_MAX;
      prevBit <= 1'b0;
      sdataQ  <= 1'b0;
    end else begin
      if (strb.frameStart) begin
        gainQ  <= gainNext;
        wordCh <= newCh;
        if (take) heldCh <= inCh;
      end
      if (strb.fall) begin
        prevBit <= normBit;
        sdataQ  <= strb.i2sNext ? prevBit : normBit;
      end
    end
  end

  assign sdataOut = sdataQ;

  // R6
  gain_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> ((gainQ == $past(gainQ)) || (gainQ == $past(gainQ) + 1'b1)
                         || (gainQ == $past(gainQ) - 1'b1)));
  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameStart |=> $stable(gainQ));
  // R11
  sdata_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fall |=> $stable(sdataOut));
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameStart && cfgMuteOnErr && errIn) |=> (wordCh == '0));
endmodule

// File: rtl/pcm_serial_out.sv
module pcm_serial_out
  import pcm_out_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bclkTick,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                errIn,
  input  logic [1:0]          cfgMode,
  input  logic                cfgLrPol,
  input  logic                cfgI2s,
  input  logic                cfgSoftMute,
  input  logic                cfgMuteOnErr,
  output logic                bclkOut,
  output logic                lrclkOut,
  output logic                sdataOut,
  output logic                sampleReq,
  output logic                underrun,
  output logic                cfgErr
);
  ctrlStrobe_t strb;

  pcm_out_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bclkTick    (bclkTick),
    .sampleValid (sampleValid),
    .cfgMode     (cfgMode),
    .cfgLrPol    (cfgLrPol),
    .cfgI2s      (cfgI2s),
    .strb        (strb),
    .bclkOut     (bclkOut),
    .lrclkOut    (lrclkOut),
    .sampleReady (sampleReady),
    .sampleReq   (sampleReq),
    .underrun    (underrun),
    .cfgErr      (cfgErr)
  );

  pcm_out_dp #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .sampleValid  (sampleValid),
    .leftIn       (leftIn),
    .rightIn      (rightIn),
    .errIn        (errIn),
    .cfgSoftMute  (cfgSoftMute),
    .cfgMuteOnErr (cfgMuteOnErr),
    .sdataOut     (sdataOut)
  );
endmodule

// File: tb/pcm_serial_out_bench.sv
`timescale 1ns/1ps
module pcm_serial_out_bench;
  logic        clk = 1'b0;
  logic        rstN, bclkTick, sampleValid, errIn;
  logic [15:0] leftIn, rightIn;
  logic [1:0]  cfgMode;
  logic        cfgLrPol, cfgI2s, cfgSoftMute, cfgMuteOnErr;
  logic        sampleReady, bclkOut, lrclkOut, sdataOut, sampleReq, underrun, cfgErr;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pcm_serial_out u_pcm_serial_out (
    .clk(clk), .rstN(rstN), .bclkTick(bclkTick), .sampleValid(sampleValid),
    .sampleReady(sampleReady), .leftIn(leftIn), .rightIn(rightIn), .errIn(errIn),
    .cfgMode(cfgMode), .cfgLrPol(cfgLrPol), .cfgI2s(cfgI2s),
    .cfgSoftMute(cfgSoftMute), .cfgMuteOnErr(cfgMuteOnErr),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdataOut(sdataOut),
    .sampleReq(sampleReq), .underrun(underrun), .cfgErr(cfgErr)
  );

  // Bit log taken at each rising bit clock, plus strobe counters.
  logic lrLog [0:1023];
  logic dLog  [0:1023];
  int   n = 0;
  bit   logEn = 0;
  logic prevB = 1'b0;
  int   readyCnt = 0, reqCnt = 0, undCnt = 0;

  always @(negedge clk) begin
    if (logEn) begin
      if (bclkOut && !prevB && n < 1024) begin
        lrLog[n] = lrclkOut;
        dLog[n]  = sdataOut;
        n++;
      end
      if (sampleReady && sampleValid) readyCnt++;
      if (sampleReq) reqCnt++;
      if (underrun) undCnt++;
    end
    prevB = bclkOut;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] scl(input logic [15:0] x, input int g);
    int p;
    if (g == 63) return x;
    p = int'($signed(x)) * g;
    p = p >>> 6;
    return p[15:0];
  endfunction

  task automatic setCfg(input logic [1:0] m, input logic pol, input logic i2s,
                        input logic sm, input logic moe);
    cfgMode = m; cfgLrPol = pol; cfgI2s = i2s; cfgSoftMute = sm; cfgMuteOnErr = moe;
  endtask

  task automatic capture(input int clks);
    n = 0; readyCnt = 0; reqCnt = 0; undCnt = 0; logEn = 1;
    repeat (clks) @(negedge clk);
    logEn = 0;
  endtask

  task automatic waitMid();
    @(negedge clk);
    while (!sampleReq) @(negedge clk);
  endtask

  // Decode one full frame from the log and compare.
  task automatic checkStream(input string req, input int mode, input logic pol,
                             input logic i2s, input logic [15:0] eL, input logic [15:0] eR);
    int half = (mode == 0) ? 16 : (mode == 1) ? 24 : 32;
    int start = -1;
    int off = i2s ? 1 : 0;
    bit lenOk = 1, padOk = 1;
    logic [15:0] gL = '0, gR = '0;
    for (int i = 1; i + 2*half + 1 < n; i++)
      if (start < 0 && lrLog[i] == pol && lrLog[i-1] != pol) start = i;
    chk(start >= 0, "R3", "left slot start found", start, 0);
    if (start < 0) return;
    for (int k = 0; k < half; k++) begin
      if (lrLog[start+k] != pol) lenOk = 0;
      if (lrLog[start+half+k] == pol) lenOk = 0;
    end
    if (lrLog[start+2*half] != pol) lenOk = 0;
    chk(lenOk, "R1", "slot length", half, half);
    for (int k = 0; k < 16; k++) begin
      gL[15-k] = dLog[start+off+k];
      gR[15-k] = dLog[start+half+off+k];
    end
    for (int k = 16; k < half; k++)
      if (dLog[start+off+k] || dLog[start+half+off+k]) padOk = 0;
    chk(padOk, "R4", "zero padding", 1, 1);
    chk(gL == eL, req, "left word", gL, eL);
    chk(gR == eR, req, "right word", gR, eR);
  endtask

  task automatic settleAndCheck(input string req, input int mode, input logic pol,
                                input logic i2s, input logic [15:0] eL, input logic [15:0] eR);
    repeat (300) @(negedge clk);
    capture(400);
    checkStream(req, mode, pol, i2s, eL, eR);
  endtask

  task automatic testReset();
    chk(bclkOut == 0 && lrclkOut == 0 && sdataOut == 0, "R13", "serial outputs after reset",
        {bclkOut, lrclkOut, sdataOut}, 0);
    chk(sampleReady == 0 && sampleReq == 0 && underrun == 0 && cfgErr == 0, "R13",
        "strobes after reset", {sampleReady, sampleReq, underrun, cfgErr}, 0);
    repeat (4) @(negedge clk);
    chk(bclkOut == 0, "R11", "bclk holds without tick", bclkOut, 0);
    bclkTick = 1;
    @(negedge clk);
    bclkTick = 0;
    chk(bclkOut == 1, "R11", "bclk toggles on tick", bclkOut, 1);
    @(negedge clk);
    chk(bclkOut == 1, "R11", "bclk holds after tick", bclkOut, 1);
    bclkTick = 1;
  endtask

  task automatic testFormats();
    setCfg(2'b00, 0, 0, 0, 0);
    settleAndCheck("R4", 0, 0, 0, leftIn, rightIn);
    chk(cfgErr == 0, "R2", "no config error for 00", cfgErr, 0);
    setCfg(2'b01, 0, 0, 0, 0);
    settleAndCheck("R1", 1, 0, 0, leftIn, rightIn);
    setCfg(2'b10, 0, 0, 0, 0);
    settleAndCheck("R1", 2, 0, 0, leftIn, rightIn);
    chk(cfgErr == 0, "R2", "no config error for 10", cfgErr, 0);
    setCfg(2'b11, 0, 0, 0, 0);
    settleAndCheck("R2", 3, 0, 0, leftIn, rightIn);
    chk(cfgErr == 1, "R2", "config error for reserved", cfgErr, 1);
    setCfg(2'b00, 1, 0, 0, 0);
    settleAndCheck("R3", 0, 1, 0, leftIn, rightIn);
    chk(cfgErr == 0, "R2", "config error clears", cfgErr, 0);
  endtask

  task automatic testI2s();
    setCfg(2'b00, 0, 1, 0, 0);
    settleAndCheck("R5", 0, 0, 1, leftIn, rightIn);
    setCfg(2'b01, 1, 1, 0, 0);
    settleAndCheck("R5", 1, 1, 1, leftIn, rightIn);
    setCfg(2'b00, 0, 0, 0, 0);
  endtask

  task automatic testErrMute();
    errIn = 1;
    setCfg(2'b00, 0, 0, 0, 1);
    settleAndCheck("R7", 0, 0, 0, 16'h0000, 16'h0000);
    setCfg(2'b00, 0, 0, 0, 0);
    settleAndCheck("R7", 0, 0, 0, leftIn, rightIn);
    errIn = 0;
  endtask

  task automatic testSoftMute();
    setCfg(2'b00, 0, 0, 0, 0);
    repeat (300) @(negedge clk);
    waitMid();
    cfgSoftMute = 1;
    capture(300);
    checkStream("R6", 0, 0, 0, scl(leftIn, 62), scl(rightIn, 62));
    repeat (4400) @(negedge clk);
    capture(300);
    checkStream("R6", 0, 0, 0, 16'h0000, 16'h0000);
    waitMid();
    cfgSoftMute = 0;
    capture(300);
    checkStream("R6", 0, 0, 0, scl(leftIn, 1), scl(rightIn, 1));
    repeat (4400) @(negedge clk);
    capture(300);
    checkStream("R6", 0, 0, 0, leftIn, rightIn);
  endtask

  task automatic testHandshake();
    setCfg(2'b00, 0, 0, 0, 0);
    repeat (300) @(negedge clk);
    waitMid();
    capture(256);
    chk(readyCnt == 4, "R8", "accepted pairs in 4 frames", readyCnt, 4);
    chk(reqCnt == 4, "R12", "request pulses in 4 frames", reqCnt, 4);
    chk(undCnt == 0, "R9", "no underrun while valid", undCnt, 0);
    leftIn = 16'h1357; rightIn = 16'hF00D;
    settleAndCheck("R8", 0, 0, 0, 16'h1357, 16'hF00D);
  endtask

  task automatic testUnderrun();
    logic [15:0] oldL = leftIn, oldR = rightIn;
    waitMid();
    sampleValid = 0;
    leftIn = 16'h1111; rightIn = 16'h2222;
    capture(256);
    chk(undCnt == 4, "R9", "underrun pulses", undCnt, 4);
    chk(readyCnt == 0, "R9", "no pair accepted", readyCnt, 0);
    settleAndCheck("R9", 0, 0, 0, oldL, oldR);
    sampleValid = 1;
    settleAndCheck("R8", 0, 0, 0, 16'h1111, 16'h2222);
  endtask

  task automatic testMidChange();
    int first = -1;
    bit runOk = 1;
    setCfg(2'b00, 0, 0, 0, 0);
    repeat (300) @(negedge clk);
    waitMid();
    cfgMode = 2'b10;
    capture(400);
    for (int i = 1; i < n; i++)
      if (first < 0 && lrLog[i] == 0 && lrLog[i-1] == 1) first = i;
    chk(first == 16, "R10", "old frame finishes right slot", first, 16);
    for (int i = 16; i < 48; i++) if (lrLog[i] != 0) runOk = 0;
    if (lrLog[48] != 1) runOk = 0;
    chk(runOk, "R10", "new frame uses new length", 32, 32);
  endtask

  initial begin
    rstN = 0; bclkTick = 0; sampleValid = 1; errIn = 0;
    leftIn = 16'h4C3B; rightIn = 16'hA5F1;
    setCfg(2'b00, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testFormats();
    testI2s();
    testErrMute();
    testSoftMute();
    testHandshake();
    testUnderrun();
    testMidChange();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule